// File: doc/BRIEF.md
# Trigger-Qualified Capture Sequencer

This block controls a circular sample buffer in on-chip memory for an embedded logic analyser. After an arm pulse it stores a programmable number of probe samples before any trigger is accepted. It then keeps storing while it waits for a trigger. Once the trigger sample is stored, it fills the rest of the buffer and stops. The trigger can come from an internal condition, from a rising edge on an asynchronous external pin, or from either one. A capture mode decides whether every clock cycle is stored or only cycles on which a qualifier input is high.

When capture finishes, a valid/ready read stream returns the whole buffer, oldest sample first. A pulse on `rd_start` starts the stream. `rd_valid` and `rd_data` hold while `rd_ready` is low, and the beat with `rd_last` set is the final one. A separate registered trigger output can pass on the internal condition, the synchronised external pin, their OR, or stay low. Host access to the settings is handled outside the block.

Top module: `capture_sequencer`

## Requirements
- R1: After reset, `phase` is 0 (idle), and `wr_en`, `rd_valid` and `ext_trig_out` are all low.
- R2: `phase` encodes idle=0, pre-trigger=1, waiting=2, post-trigger=3, done=4. An `arm` pulse in idle, or in done with no readout in progress, gives phase 1 on the next cycle. `abort` gives phase 0 on the next cycle from any phase and suppresses that cycle's write.
- R3: In pre-trigger the block stores until `pre_count` samples have been stored, then moves to waiting. Triggers seen during pre-trigger are ignored.
- R4: `trig_src` is latched at arm and selects the trigger source: 00 = internal condition, 01 = external rising edge, 10 or 11 = the OR of the two. Only in waiting does a trigger move the block to post-trigger.
- R5: The external pin passes through a two-stage synchroniser. A rising edge is seen when the synchronised level is high and its registered previous value is low. A pin that stays high raises no trigger, and the edge acts on the third clock edge after the pin rises.
- R6: `cap_basic` is latched at arm. With 0, every cycle in pre-trigger, waiting and post-trigger is stored. With 1, only cycles with `cap_qual` high are stored. The trigger sample is always stored.
- R7: After the trigger sample, the block stores 2^ADDR_W-1-`pre_count` more samples and then enters done. It writes nothing in done or idle, and `wr_addr` steps by one after each write.
- R8: `ext_trig_out` is registered. `tout_sel` 00 drives it low, 01 passes the internal condition, 10 passes the synchronised external level, and 11 passes their OR.
- R9: `rd_start` in done streams all 2^ADDR_W samples, oldest first. The trigger sample is at index `pre_count` and `rd_last` marks the final beat. `trig_addr` equals `wr_addr + pre_count` modulo the depth.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. An arm pulse during a readout is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a capture (pulse) |
| abort | input | 1 | Return to idle (pulse) |
| trig_src | input | 2 | Trigger source select |
| cap_basic | input | 1 | 1 = qualified capture, 0 = every cycle |
| pre_count | input | ADDR_W | Samples stored before a trigger is accepted |
| tout_sel | input | 2 | Trigger output mode |
| int_trig | input | 1 | Internal trigger condition |
| cap_qual | input | 1 | Capture qualifier |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| probe_data | input | DATA_W | Probe sample bus |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | ADDR_W | Buffer write address |
| trig_addr | output | ADDR_W | Address of the trigger sample |
| phase | output | 3 | Capture phase |
| ext_trig_out | output | 1 | External trigger output |
| rd_start | input | 1 | Start readout (pulse, accepted in done) |
| rd_ready | input | 1 | Read stream ready |
| rd_valid | output | 1 | Read stream valid |
| rd_data | output | DATA_W | Read stream sample |
| rd_last | output | 1 | Final beat of the readout |

## Verification
The properties assume that `arm`, `abort` and `rd_start` are single-cycle pulses. They also assume that `pre_count` and the capture settings do not change between an arm and done. The hold property on the read stream is conditioned on no `abort`, because an abort deliberately clears the stream. The bench changes every input on the falling clock edge, keeps `abort` low while reading, and moves the external pin only while its effect is being measured.

// File: rtl/capseq_pkg.sv
package capseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_WAIT = 3'd2,
    PH_POST = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  localparam logic [1:0] SRC_INTERNAL = 2'b00;
  localparam logic [1:0] SRC_EXT_EDGE = 2'b01;

  localparam logic [1:0] TOUT_OFF      = 2'b00;
  localparam logic [1:0] TOUT_INTERNAL = 2'b01;
  localparam logic [1:0] TOUT_EXTERNAL = 2'b10;
  localparam logic [1:0] TOUT_EITHER   = 2'b11;
endpackage

// File: rtl/capseq_sync.sv
module capseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/capseq_ctrl.sv
module capseq_ctrl
  import capseq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              abort,
  input  logic              rd_busy,
  input  logic [1:0]        trig_src,
  input  logic              cap_basic,
  input  logic [ADDR_W-1:0] pre_count,
  input  logic              int_trig,
  input  logic              ext_rise,
  input  logic              cap_qual,
  output phase_e            phase,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] trig_addr,
  output logic              cfg_basic
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  phase_e            ph_q, ph_d;
  logic [ADDR_W-1:0] ptr_q, trig_q, trig_d, pre_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, post_need, pre_ext;
  logic [1:0]        src_q;
  logic              basic_q, qual_ok, hit, take_arm, we;

  assign pre_ext   = {1'b0, pre_q};
  assign post_need = CNT_W'(DEPTH - 1) - pre_ext;
  assign qual_ok   = !basic_q || cap_qual;

  always_comb begin
    case (src_q)
      SRC_INTERNAL: hit = int_trig;
      SRC_EXT_EDGE: hit = ext_rise;
      default:      hit = int_trig | ext_rise;
    endcase
  end

  assign take_arm = arm && (ph_q == PH_IDLE || (ph_q == PH_DONE && !rd_busy));

  always_comb begin
    ph_d   = ph_q;
    we     = 1'b0;
    cnt_d  = cnt_q;
    trig_d = trig_q;
    case (ph_q)
      PH_PRE: begin
        we    = qual_ok;
        cnt_d = cnt_q + CNT_W'(we);
        if (cnt_d >= pre_ext) ph_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (hit) begin
          we     = 1'b1;
          trig_d = ptr_q;
          cnt_d  = '0;
          ph_d   = (post_need == '0) ? PH_DONE : PH_POST;
        end else begin
          we = qual_ok;
        end
      end
      PH_POST: begin
        we    = qual_ok;
        cnt_d = cnt_q + CNT_W'(we);
        if (cnt_d == post_need) ph_d = PH_DONE;
      end
      default: ;
    endcase
    if (abort) begin
      ph_d = PH_IDLE;
      we   = 1'b0;
    end else if (take_arm) begin
      ph_d  = PH_PRE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      ptr_q   <= '0;
      trig_q  <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
      src_q   <= SRC_INTERNAL;
      basic_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      trig_q <= trig_d;
      ptr_q  <= ptr_q + ADDR_W'(we);
      if (!abort && take_arm) begin
        pre_q   <= pre_count;
        src_q   <= trig_src;
        basic_q <= cap_basic;
      end
    end
  end

  assign phase     = ph_q;
  assign wr_en     = we;
  assign wr_addr   = ptr_q;
  assign trig_addr = trig_q;
  assign cfg_basic = basic_q;
endmodule

// File: rtl/capseq_buffer.sv
module capseq_buffer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/capseq_readout.sv
module capseq_readout #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              flush,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              rd_ready,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_valid,
  output logic              rd_last,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEFT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] ptr_q;
  logic [LEFT_W-1:0] left_q;
  logic              valid_q, last_q;

  assign re    = !flush && (left_q != '0) && (!valid_q || rd_ready);
  assign raddr = ptr_q;
  assign busy  = (left_q != '0) || valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      left_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (flush) begin
      left_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (start && !busy) begin
      ptr_q  <= base_addr;
      left_q <= LEFT_W'(DEPTH);
    end else if (re) begin
      ptr_q   <= ptr_q + 1'b1;
      left_q  <= left_q - 1'b1;
      valid_q <= 1'b1;
      last_q  <= (left_q == LEFT_W'(1));
    end else if (rd_ready) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

  assign rd_valid = valid_q;
  assign rd_last  = last_q;
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import capseq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              abort,
  input  logic [1:0]        trig_src,
  input  logic              cap_basic,
  input  logic [ADDR_W-1:0] pre_count,
  input  logic [1:0]        tout_sel,
  input  logic              int_trig,
  input  logic              cap_qual,
  input  logic              ext_trig_in,
  input  logic [DATA_W-1:0] probe_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [2:0]        phase,
  output logic              ext_trig_out,
  input  logic              rd_start,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  phase_e            ph;
  logic              ext_level, ext_rise, rd_busy, cfg_basic;
  logic              re;
  logic [ADDR_W-1:0] raddr;
  logic              tout_d, tout_q;

  capseq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_trig_in),
    .level(ext_level), .rise(ext_rise)
  );

  capseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort), .rd_busy(rd_busy),
    .trig_src(trig_src), .cap_basic(cap_basic), .pre_count(pre_count),
    .int_trig(int_trig), .ext_rise(ext_rise), .cap_qual(cap_qual),
    .phase(ph), .wr_en(wr_en), .wr_addr(wr_addr), .trig_addr(trig_addr),
    .cfg_basic(cfg_basic)
  );

  capseq_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(probe_data),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  capseq_readout #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start && ph == PH_DONE),
    .flush(abort), .base_addr(wr_addr), .rd_ready(rd_ready),
    .re(re), .raddr(raddr), .rd_valid(rd_valid), .rd_last(rd_last),
    .busy(rd_busy)
  );

  always_comb begin
    case (tout_sel)
      TOUT_INTERNAL: tout_d = int_trig;
      TOUT_EXTERNAL: tout_d = ext_level;
      TOUT_EITHER:   tout_d = int_trig | ext_level;
      default:       tout_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tout_q <= 1'b0;
    else        tout_q <= tout_d;
  end

  assign ext_trig_out = tout_q;
  assign phase        = ph;
endmodule

// File: rtl/capseq_checker.sv
module capseq_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              abort,
  input logic [1:0]        tout_sel,
  input logic              cap_qual,
  input logic [2:0]        phase,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cfg_basic,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              ext_trig_out
);
  assert_arm_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && arm && !abort) |=> phase == 3'd1);

  assert_abort_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> phase == 3'd0);

  assert_pre_to_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && !abort) |=> (phase == 3'd1 || phase == 3'd2));

  assert_basic_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && cfg_basic && wr_en) |-> cap_qual);

  assert_write_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (phase == 3'd1 || phase == 3'd2 || phase == 3'd3));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && !arm && !abort) |=> phase == 3'd4);

  assert_tout_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_sel == 2'b00) |=> !ext_trig_out);

  assert_read_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> phase == 3'd4);

  assert_stream_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !abort) |=> (rd_valid && $stable(rd_data)));
endmodule

bind capture_sequencer capseq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort), .tout_sel(tout_sel),
  .cap_qual(cap_qual), .phase(phase), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg_basic(cfg_basic), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .ext_trig_out(ext_trig_out)
);

// File: tb/sim_capture_sequencer.sv
module sim_capture_sequencer;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, abort = 1'b0, cap_basic = 1'b0, int_trig = 1'b0;
  logic ext_trig_in = 1'b0, rd_start = 1'b0, rd_ready = 1'b1;
  logic [1:0] trig_src = 2'b00, tout_sel = 2'b00;
  logic [AW-1:0] pre_count = '0;
  logic [DW-1:0] probe = '0;
  logic qual_gen = 1'b0;
  logic cap_qual;
  logic wr_en, ext_trig_out, rd_valid, rd_last;
  logic [AW-1:0] wr_addr, trig_addr;
  logic [2:0] phase;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  logic [DW-1:0] got [DEPTH];
  logic got_last [DEPTH];

  always #10 clk = ~clk;
  always @(posedge clk) probe <= probe + 1'b1;
  assign cap_qual = qual_gen ? ~probe[0] : 1'b1;

  capture_sequencer #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort), .trig_src(trig_src),
    .cap_basic(cap_basic), .pre_count(pre_count), .tout_sel(tout_sel),
    .int_trig(int_trig), .cap_qual(cap_qual), .ext_trig_in(ext_trig_in),
    .probe_data(probe), .wr_en(wr_en), .wr_addr(wr_addr), .trig_addr(trig_addr),
    .phase(phase), .ext_trig_out(ext_trig_out), .rd_start(rd_start),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_phase(input logic [2:0] p);
    int k = 0;
    while (phase != p && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic count_to_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (phase != 3'd4 && n < 2000);
  endtask

  task automatic do_arm(input logic [1:0] src, input logic basic, input int pre);
    @(negedge clk);
    trig_src = src; cap_basic = basic; pre_count = AW'(pre); arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    check("R2 arm enters pre-trigger", phase, 3'd1);
  endtask

  task automatic pulse_int(output logic [DW-1:0] v);
    v = probe;
    int_trig = 1'b1;
    @(negedge clk);
    int_trig = 1'b0;
  endtask

  task automatic read_all(input bit stall, input bit try_arm);
    int n = 0, k = 0;
    bit held_flag = 0;
    logic [DW-1:0] held = '0;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    while (n < DEPTH && k < 1000) begin
      arm = (try_arm && n == 5 && k < 40);
      if (held_flag) begin
        check("R10 valid held under back-pressure", rd_valid, 1'b1);
        check("R10 data held under back-pressure", rd_data, held);
      end
      if (rd_valid) begin
        if (stall && (n % 4 == 2) && !held_flag) begin
          rd_ready = 1'b0; held = rd_data; held_flag = 1;
        end else begin
          rd_ready = 1'b1; got[n] = rd_data; got_last[n] = rd_last; n++; held_flag = 0;
        end
      end else begin
        rd_ready = 1'b1;
      end
      @(negedge clk);
      k++;
    end
    arm = 1'b0; rd_ready = 1'b1;
    check("R9 beat count", n, DEPTH);
    check("R9 last flag on final beat", got_last[DEPTH-1], 1'b1);
    check("R9 no last flag before final beat", got_last[DEPTH-2], 1'b0);
  endtask

  task automatic cmp_contig(input string req, input int pre, input logic [DW-1:0] tv);
    for (int i = 0; i < DEPTH; i++)
      check(req, got[i], DW'(int'(tv) - pre + i));
  endtask

  task automatic t_reset;
    check("R1 phase idle", phase, 3'd0);
    check("R1 wr_en low", wr_en, 1'b0);
    check("R1 rd_valid low", rd_valid, 1'b0);
    check("R1 trigger out low", ext_trig_out, 1'b0);
  endtask

  task automatic t_tout;
    logic exp_i [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    logic exp_e [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      tout_sel = 2'(m); int_trig = 1'b1;
      @(negedge clk);
      check("R8 trigger out from internal", ext_trig_out, exp_i[m]);
      int_trig = 1'b0; ext_trig_in = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 trigger out from external", ext_trig_out, exp_e[m]);
      ext_trig_in = 1'b0;
      repeat (4) @(negedge clk);
    end
    tout_sel = 2'b00;
  endtask

  task automatic t_always_int;
    logic [DW-1:0] tv;
    int n;
    do_arm(2'b00, 1'b0, 5);
    pulse_int(tv);
    check("R3 early trigger ignored", phase, 3'd1);
    wait_phase(3'd2);
    repeat (3) @(negedge clk);
    pulse_int(tv);
    check("R4 internal trigger starts post", phase, 3'd3);
    count_to_done(n);
    check("R7 post length", n, DEPTH - 1 - 5);
    check("R7 no write in done", wr_en, 1'b0);
    check("R9 trigger address", trig_addr, AW'(wr_addr + 5));
    read_all(0, 0);
    cmp_contig("R9 time-ordered samples", 5, tv);
  endtask

  task automatic t_basic;
    logic [DW-1:0] tv;
    int n;
    qual_gen = 1'b1;
    do_arm(2'b00, 1'b1, 4);
    wait_phase(3'd2);
    @(negedge clk);
    if (probe[0] == 1'b0) @(negedge clk);
    pulse_int(tv);
    count_to_done(n);
    check("R6 qualified post length", n, 2 * (DEPTH - 1 - 4) - 1);
    qual_gen = 1'b0;
    read_all(0, 0);
    check("R6 trigger sample stored unqualified", got[4], tv);
    for (int i = 0; i < 4; i++)
      check("R6 qualified pre samples", got[i], DW'(int'(tv) - 1 - 2 * (3 - i)));
    for (int i = 5; i < DEPTH; i++)
      check("R6 qualified post samples", got[i], DW'(int'(tv) + 1 + 2 * (i - 5)));
  endtask

  task automatic t_ext;
    logic [DW-1:0] p, tv;
    ext_trig_in = 1'b1;
    repeat (5) @(negedge clk);
    do_arm(2'b01, 1'b0, 0);
    wait_phase(3'd2);
    pulse_int(tv);
    repeat (6) @(negedge clk);
    check("R5 held pin and internal give no trigger", phase, 3'd2);
    ext_trig_in = 1'b0;
    repeat (4) @(negedge clk);
    p = probe;
    ext_trig_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 edge not yet seen", phase, 3'd2);
    @(negedge clk);
    check("R5 edge seen on third clock", phase, 3'd3);
    ext_trig_in = 1'b0;
    tv = p + 2'd2;
    wait_phase(3'd4);
    read_all(0, 0);
    check("R5 trigger sample at index 0", got[0], tv);
    cmp_contig("R4 ext-edge capture order", 0, tv);
  endtask

  task automatic t_or_full;
    logic [DW-1:0] tv;
    do_arm(2'b10, 1'b0, DEPTH - 1);
    wait_phase(3'd2);
    @(negedge clk);
    pulse_int(tv);
    check("R7 full pre-count ends at trigger", phase, 3'd4);
    check("R9 trigger address", trig_addr, AW'(wr_addr + DEPTH - 1));
    read_all(1, 1);
    check("R10 arm ignored during readout", phase, 3'd4);
    check("R4 or-mode trigger sample last", got[DEPTH-1], tv);
    cmp_contig("R9 order with stalls", DEPTH - 1, tv);
  endtask

  task automatic t_abort;
    do_arm(2'b00, 1'b0, 3);
    wait_phase(3'd2);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check("R2 abort returns idle", phase, 3'd0);
    check("R2 no write after abort", wr_en, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tout();
    t_always_int();
    t_basic();
    t_ext();
    t_or_full();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule